// File: doc/BRIEF.md
# Reset Sequencer with Configuration Strap Capture

This block produces the chip-wide reset from two requests: an active-low board reset pin and an overflow request from the watchdog timer. The pin puts the core into reset at once, with no clock edge needed. Leaving reset is tied to the master clock through a two-stage synchroniser and a short hold counter. Any clock that is running while the pin is low therefore ends reset cleanly, whatever the pin's timing.

The last few clock edges before a pin-driven reset ends form a sampling window for two configuration inputs. The first is a request to float all chip outputs, which counts only if it is low on every edge of the window. The second is a boot-width select, decided by a vote over the window. A debug/scan select input is taken once, on the way out of power-up. A watchdog overflow is routed by a 2-bit mode: it can start an internal reset, raise an interrupt, drive a pulse on an overflow pin that the board can loop back to the reset pin, or be ignored. The block keeps a signature byte that records what caused the last reset. It also has a small registered read port that returns the signature and the latched configuration.

Top module: `rst_strap_ctrl`

## Requirements
- R1: A low level on `ext_rst_n` (or `por_n`) sets `sys_rst` to 1 at once, before any clock edge.
- R2: After `ext_rst_n` rises, `sys_rst` stays 1 through the first four rising clock edges and is 0 after the fifth. This is two synchroniser edges plus STRETCH=2 hold edges plus one output register.
- R3: The float request latch (strap bit 0) is set to 1 only if `hiz_req_n` was low on all 10 edges of the window. The window is the 10 rising edges that end with the second edge after the reset pin rises. Any high sample clears the latch to 0.
- R4: The boot select latch (strap bit 1) is decided by the window samples of `boot_sel`. More than 5 ones gives 1 (8-bit boot memory on chip-select 0). Fewer than 5 ones gives 0 (16-bit boot memory on chip-select 0). Exactly 5 ones gives the default 0.
- R5: The debug latch (strap bit 2) takes `dbg_sel` on the second rising edge after `por_n` rises and keeps it until the next power-up. A value of 0 selects in-circuit debug and 1 selects boundary scan. Pin resets leave it unchanged.
- R6: The cause byte reads 0x6C after power-up and after every reset driven by the pin.
- R7: With `wdt_mode`=0 (internal reset), a `wdt_ovf` seen on an edge sets the cause byte to 0x53 on that edge. It also holds `sys_rst` at 1 from that edge for 3 cycles.
- R8: A watchdog reset leaves the float and boot latches unchanged, whatever the strap inputs are doing.
- R9: With `wdt_mode`=1 (interrupt), a `wdt_ovf` gives a one-cycle `wdt_irq` pulse on the edge that sees it. There is no reset and the cause byte does not change.
- R10: With `wdt_mode`=2 (pin drive), a `wdt_ovf` drives `wdt_ovf_n` low for OVF_LEN=4 cycles starting at the edge that sees it. There is no internal reset.
- R11: A `wdt_ovf` has no effect with `wdt_mode`=3, or while `sys_rst` is 1.
- R12: `rd_data` is registered with one cycle of latency. Address 0 returns the cause byte, address 1 returns {5'b0, debug, boot, float}, and addresses 2 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| por_n | input | 1 | Power-up reset from the analog detector, active low |
| ext_rst_n | input | 1 | Board reset pin, active low |
| hiz_req_n | input | 1 | Strap: request to float all outputs, active low |
| boot_sel | input | 1 | Strap: boot memory width select |
| dbg_sel | input | 1 | Strap: debug (0) or boundary scan (1), power-up only |
| wdt_ovf | input | 1 | Watchdog overflow request, one clock wide |
| wdt_mode | input | 2 | Overflow action: 0 reset, 1 interrupt, 2 pin, 3 none |
| rd_addr | input | ADDR_W | Read port address |
| sys_rst | output | 1 | Internal system reset, active high |
| wdt_irq | output | 1 | Watchdog interrupt pulse |
| wdt_ovf_n | output | 1 | Watchdog overflow pin drive, active low |
| rd_data | output | 8 | Registered read data |

## Verification
Each result is due a fixed number of edges after its stimulus. `sys_rst` rises within the same cycle as the pin falls, and falls on the fifth edge after the pin rises. The strap latches update on the second edge after release, and debug on the second edge after power-up. The watchdog outputs react on the same edge that samples `wdt_ovf`. A read returns on the edge after the address is set. The bench drives inputs on falling edges and updates its reference model on each rising edge. It compares all outputs a quarter period later, so each expected value is set by the same edge as the design's register. The asynchronous assertion check is the one exception: it samples 1 ns after the pin falls, well before the next rising edge.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [1:0] {
    WD_RESET = 2'd0,
    WD_IRQ   = 2'd1,
    WD_PIN   = 2'd2,
    WD_OFF   = 2'd3
  } wd_mode_e;

  localparam logic [7:0] CAUSE_PIN  = 8'h6C;
  localparam logic [7:0] CAUSE_WDOG = 8'h53;

  localparam int REG_CAUSE = 0;
  localparam int REG_STRAP = 1;
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  output logic [STAGES-1:0] q
);
  // Asynchronous clear, release walks a one through the stages.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end
endmodule

// File: rtl/rsc_strap.sv
module rsc_strap #(
  parameter int WIN       = 10,
  parameter bit BOOT_VOTE = 1'b1,
  parameter bit BOOT_DEF  = 1'b0
) (
  input  logic clk,
  input  logic por_n,
  input  logic cap,
  input  logic hiz_n_pin,
  input  logic boot_pin,
  output logic hiz_q,
  output logic boot_q
);
  localparam int CW = $clog2(WIN + 1);

  logic [WIN-2:0] hiz_hist, boot_hist;
  logic [WIN-1:0] hiz_win, boot_win;
  logic           boot_dec;

  assign hiz_win  = {hiz_hist, hiz_n_pin};
  assign boot_win = {boot_hist, boot_pin};

  // Free-running history; no reset needed, shift-register friendly.
  always_ff @(posedge clk) begin
    hiz_hist  <= hiz_win[WIN-2:0];
    boot_hist <= boot_win[WIN-2:0];
  end

  generate
    if (BOOT_VOTE) begin : g_vote
      logic [CW-1:0] ones;
      always_comb begin
        ones = '0;
        for (int i = 0; i < WIN; i++) ones += CW'(boot_win[i]);
      end
      always_comb begin
        if (2 * int'(ones) > WIN)      boot_dec = 1'b1;
        else if (2 * int'(ones) < WIN) boot_dec = 1'b0;
        else                           boot_dec = BOOT_DEF;
      end
    end else begin : g_agree
      assign boot_dec = (&boot_win) ? 1'b1 : ((|boot_win) ? BOOT_DEF : 1'b0);
    end
  endgenerate

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hiz_q  <= 1'b0;
      boot_q <= BOOT_DEF;
    end else if (cap) begin
      hiz_q  <= ~|hiz_win;
      boot_q <= boot_dec;
    end
  end

  // R8: outside the capture strobe the latches never move.
  p_strap_hold_r8: assert property (@(posedge clk) disable iff (!por_n)
    !cap |=> $stable({hiz_q, boot_q}));
endmodule

// File: rtl/rsc_wdog.sv
module rsc_wdog
  import rsc_pkg::*;
#(
  parameter int OVF_LEN = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ovf_req,
  input  wd_mode_e mode,
  output logic     evt_rst,
  output logic     irq_o,
  output logic     ovf_n_o
);
  localparam int OW = $clog2(OVF_LEN + 1);

  logic          ev, ev_pin;
  logic [OW-1:0] ocnt;

  assign ev      = ovf_req & ~rst;
  assign evt_rst = ev && (mode == WD_RESET);
  assign ev_pin  = ev && (mode == WD_PIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o   <= 1'b0;
      ovf_n_o <= 1'b1;
      ocnt    <= '0;
    end else begin
      irq_o   <= ev && (mode == WD_IRQ);
      ovf_n_o <= ~(ev_pin || (ocnt > OW'(1)));
      if (ev_pin)           ocnt <= OW'(OVF_LEN);
      else if (ocnt != '0)  ocnt <= ocnt - OW'(1);
    end
  end

  // R9: an interrupt pulse always traces back to a request in interrupt mode.
  p_irq_src_r9: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ($past(ovf_req) && ($past(mode) == WD_IRQ)));

  // R10: the overflow pin only starts a pulse after a request in pin mode.
  p_ovf_src_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_n_o) |-> ($past(ovf_req) && ($past(mode) == WD_PIN)));
endmodule

// File: rtl/rst_strap_ctrl.sv
module rst_strap_ctrl
  import rsc_pkg::*;
#(
  parameter int WIN         = 10,
  parameter int STRETCH     = 2,
  parameter int OVF_LEN     = 4,
  parameter int SYNC_STAGES = 2,
  parameter bit BOOT_VOTE   = 1'b1,
  parameter bit BOOT_DEF    = 1'b0,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic              hiz_req_n,
  input  logic              boot_sel,
  input  logic              dbg_sel,
  input  logic              wdt_ovf,
  input  logic [1:0]        wdt_mode,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              sys_rst,
  output logic              wdt_irq,
  output logic              wdt_ovf_n,
  output logic [7:0]        rd_data
);
  localparam int CNT_W = $clog2(STRETCH + 1);

  logic                   raw_n;
  logic [SYNC_STAGES-1:0] ext_q, por_q;
  logic                   ext_ok, cap;
  logic [CNT_W-1:0]       hold_cnt;
  logic                   sys_rst_q;
  logic [7:0]             cause_q;
  logic                   dbg_q, hiz_q, boot_q;
  logic                   wd_rst_evt;

  assign raw_n = por_n & ext_rst_n;

  rsc_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk    (clk),
    .arst_n (raw_n),
    .q      (ext_q)
  );

  rsc_sync #(.STAGES(SYNC_STAGES)) u_por_sync (
    .clk    (clk),
    .arst_n (por_n),
    .q      (por_q)
  );

  assign ext_ok = ext_q[SYNC_STAGES-1];
  assign cap    = ext_q[SYNC_STAGES-2] & ~ext_q[SYNC_STAGES-1];

  // Reset hold, output and cause signature.
  always_ff @(posedge clk or negedge raw_n) begin
    if (!raw_n) begin
      hold_cnt  <= CNT_W'(STRETCH);
      sys_rst_q <= 1'b1;
      cause_q   <= CAUSE_PIN;
    end else begin
      if (!ext_ok || wd_rst_evt)  hold_cnt <= CNT_W'(STRETCH);
      else if (hold_cnt != '0)    hold_cnt <= hold_cnt - CNT_W'(1);
      sys_rst_q <= !ext_ok || wd_rst_evt || (hold_cnt != '0);
      if (wd_rst_evt) cause_q <= CAUSE_WDOG;
    end
  end

  assign sys_rst = sys_rst_q;

  // Debug select: taken once as the power-up synchroniser releases.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) dbg_q <= 1'b1;
    else if (por_q[SYNC_STAGES-2] & ~por_q[SYNC_STAGES-1]) dbg_q <= dbg_sel;
  end

  rsc_strap #(
    .WIN       (WIN),
    .BOOT_VOTE (BOOT_VOTE),
    .BOOT_DEF  (BOOT_DEF)
  ) u_strap (
    .clk       (clk),
    .por_n     (por_n),
    .cap       (cap),
    .hiz_n_pin (hiz_req_n),
    .boot_pin  (boot_sel),
    .hiz_q     (hiz_q),
    .boot_q    (boot_q)
  );

  rsc_wdog #(.OVF_LEN(OVF_LEN)) u_wdog (
    .clk     (clk),
    .rst     (sys_rst_q),
    .ovf_req (wdt_ovf),
    .mode    (wd_mode_e'(wdt_mode)),
    .evt_rst (wd_rst_evt),
    .irq_o   (wdt_irq),
    .ovf_n_o (wdt_ovf_n)
  );

  // Registered read port.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) rd_data <= '0;
    else begin
      case (rd_addr)
        ADDR_W'(REG_CAUSE): rd_data <= cause_q;
        ADDR_W'(REG_STRAP): rd_data <= {5'b0, dbg_q, boot_q, hiz_q};
        default:            rd_data <= '0;
      endcase
    end
  end

  // R1: a low pin is already reflected on the reset output at any edge.
  p_async_assert_r1: assert property (@(posedge clk) disable iff (!por_n)
    !ext_rst_n |-> sys_rst);

  // R7: a watchdog reset event records its signature and holds reset.
  p_wdog_cause_r7: assert property (@(posedge clk) disable iff (!raw_n)
    wd_rst_evt |=> (cause_q == CAUSE_WDOG) && sys_rst_q);

  // R5: once power-up has been left, the debug latch is frozen.
  p_dbg_frozen_r5: assert property (@(posedge clk) disable iff (!por_n)
    por_q[SYNC_STAGES-1] |=> $stable(dbg_q));
endmodule

// File: tb/rst_strap_ctrl_test.sv
module rst_strap_ctrl_test;
  localparam int CLK_P   = 10;
  localparam int WIN     = 10;
  localparam int STRETCH = 2;
  localparam int OVF_LEN = 4;
  localparam bit BOOT_DEF = 1'b0;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, ext_rst_n = 1'b0;
  logic       hiz_req_n = 1'b1, boot_sel = 1'b1, dbg_sel = 1'b0;
  logic       wdt_ovf = 1'b0;
  logic [1:0] wdt_mode = 2'd0;
  logic [1:0] rd_addr = 2'd0;
  logic       sys_rst, wdt_irq, wdt_ovf_n;
  logic [7:0] rd_data;

  always #(CLK_P/2) clk = ~clk;

  rst_strap_ctrl uut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .hiz_req_n(hiz_req_n),
    .boot_sel(boot_sel), .dbg_sel(dbg_sel), .wdt_ovf(wdt_ovf), .wdt_mode(wdt_mode),
    .rd_addr(rd_addr), .sys_rst(sys_rst), .wdt_irq(wdt_irq), .wdt_ovf_n(wdt_ovf_n),
    .rd_data(rd_data)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge.
  int m_rel = 0, m_porrel = 0, m_cnt = STRETCH, m_ocnt = 0, m_cause = 'h6C, m_rd = 0;
  bit m_sys = 1, m_irq = 0, m_ovf_n = 1, m_hiz = 0, m_boot = BOOT_DEF, m_dbg = 1;
  bit q_hiz[$], q_boot[$];

  always @(posedge clk) begin : model
    bit raw, sys_eff, evt, evr, ok_old, cap, sys_new, allz;
    int ones;
    raw = !por_n || !ext_rst_n;
    sys_eff = raw || m_sys;
    q_hiz.push_back(hiz_req_n);
    q_boot.push_back(boot_sel);
    if (q_hiz.size() > WIN) begin void'(q_hiz.pop_front()); void'(q_boot.pop_front()); end
    if (!por_n) m_rd = 0;
    else if (rd_addr == 0) m_rd = raw ? 'h6C : m_cause;
    else if (rd_addr == 1) m_rd = m_dbg * 4 + m_boot * 2 + m_hiz;
    else m_rd = 0;
    evt = wdt_ovf && !sys_eff;
    if (sys_eff) begin m_irq = 0; m_ovf_n = 1; m_ocnt = 0; end
    else begin
      m_irq = evt && wdt_mode == 2'd1;
      m_ovf_n = !((evt && wdt_mode == 2'd2) || m_ocnt > 1);
      if (evt && wdt_mode == 2'd2) m_ocnt = OVF_LEN;
      else if (m_ocnt > 0) m_ocnt--;
    end
    if (raw) begin m_rel = 0; m_cnt = STRETCH; m_sys = 1; m_cause = 'h6C; end
    else begin
      ok_old = m_rel >= 2;
      cap = m_rel == 1;
      evr = evt && wdt_mode == 2'd0;
      sys_new = !ok_old || evr || m_cnt != 0;
      if (!ok_old || evr) m_cnt = STRETCH; else if (m_cnt > 0) m_cnt--;
      if (evr) m_cause = 'h53;
      if (cap) begin
        allz = 1; ones = 0;
        foreach (q_hiz[i]) if (q_hiz[i]) allz = 0;
        foreach (q_boot[i]) ones += int'(q_boot[i]);
        m_hiz = allz;
        m_boot = (2 * ones > WIN) ? 1'b1 : ((2 * ones < WIN) ? 1'b0 : BOOT_DEF);
      end
      m_sys = sys_new;
      if (m_rel < 3) m_rel++;
    end
    if (!por_n) begin m_porrel = 0; m_dbg = 1; m_hiz = 0; m_boot = BOOT_DEF; end
    else begin
      if (m_porrel == 1) m_dbg = dbg_sel;
      if (m_porrel < 3) m_porrel++;
    end
    cyc++;
  end

  // Every-clock comparison a quarter period after the edge.
  always @(posedge clk) begin
    #(CLK_P/4);
    if (cyc >= 2 && !done) begin
      chk("R2 sys_rst vs model", int'(sys_rst), int'(m_sys));
      chk("R9 wdt_irq vs model", int'(wdt_irq), int'(m_irq));
      chk("R10 wdt_ovf_n vs model", int'(wdt_ovf_n), int'(m_ovf_n));
      chk("R12 rd_data vs model", int'(rd_data), m_rd);
    end
  end

  task automatic rd(int addr, int exp, string tag);
    @(negedge clk); rd_addr = 2'(addr);
    @(posedge clk); #(CLK_P/4);
    chk(tag, int'(rd_data), exp);
  endtask

  task automatic ext_cycle(logic [9:0] hp, logic [9:0] bp);
    @(negedge clk); ext_rst_n = 1'b0;
    #1 chk("R1 async assert", int'(sys_rst), 1);
    repeat (4) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      hiz_req_n = hp[9-k];
      boot_sel  = bp[9-k];
      if (k == 8) ext_rst_n = 1'b1;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic pulse_ovf(logic [1:0] mode);
    @(negedge clk); wdt_mode = mode; wdt_ovf = 1'b1;
    @(posedge clk); #(CLK_P/4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset held while pin low", int'(sys_rst), 1);
    rd(0, 'h6C, "R6 cause in reset state");
    repeat (8) @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #(CLK_P/4) chk("R2 held through 4th edge", int'(sys_rst), 1);
    @(posedge clk);
    #(CLK_P/4) chk("R2 released at 5th edge", int'(sys_rst), 0);
    rd(0, 'h6C, "R6 cause after power-up");
    rd(1, 3'b010, "R3 R4 R5 power-up straps");

    dbg_sel = 1'b1;
    ext_cycle(10'b0, 10'b0);
    rd(1, 3'b001, "R3 all-low float, R5 debug kept");
    ext_cycle(10'b0000100000, 10'b1111100000);
    rd(1, 3'b000, "R3 one high sample, R4 tie default");
    ext_cycle(10'b0, 10'b1110110100);
    rd(1, 3'b011, "R4 majority one");
    ext_cycle(10'h3FF, 10'b0001000000);
    rd(1, 3'b000, "R4 majority zero");

    @(negedge clk); hiz_req_n = 1'b0; boot_sel = 1'b1;
    pulse_ovf(2'd0);
    chk("R7 watchdog reset asserted", int'(sys_rst), 1);
    @(negedge clk); wdt_ovf = 1'b0;
    repeat (6) @(negedge clk);
    rd(0, 'h53, "R7 watchdog cause");
    rd(1, 3'b000, "R8 straps kept over watchdog reset");
    ext_cycle(10'h3FF, 10'h3FF);
    rd(0, 'h6C, "R6 pin reset cause");
    rd(1, 3'b010, "R3 R4 straps after pin reset");

    pulse_ovf(2'd1);
    chk("R9 irq pulse", int'(wdt_irq), 1);
    chk("R9 no reset", int'(sys_rst), 0);
    @(negedge clk); wdt_ovf = 1'b0;
    @(posedge clk); #(CLK_P/4) chk("R9 irq one cycle", int'(wdt_irq), 0);
    rd(0, 'h6C, "R9 cause unchanged");

    pulse_ovf(2'd2);
    chk("R10 ovf pin low", int'(wdt_ovf_n), 0);
    @(negedge clk); wdt_ovf = 1'b0;
    for (int i = 0; i < OVF_LEN - 1; i++) begin
      @(posedge clk); #(CLK_P/4) chk("R10 ovf pin still low", int'(wdt_ovf_n), 0);
    end
    @(posedge clk); #(CLK_P/4) chk("R10 ovf pin released", int'(wdt_ovf_n), 1);
    chk("R10 no reset", int'(sys_rst), 0);

    pulse_ovf(2'd3);
    chk("R11 off mode no irq", int'(wdt_irq), 0);
    chk("R11 off mode no reset", int'(sys_rst), 0);
    @(negedge clk); wdt_ovf = 1'b0;
    @(posedge clk); #(CLK_P/4) chk("R11 off mode no pin", int'(wdt_ovf_n), 1);
    rd(0, 'h6C, "R11 off mode cause");

    @(negedge clk); wdt_mode = 2'd0; ext_rst_n = 1'b0; wdt_ovf = 1'b1;
    repeat (3) @(negedge clk);
    wdt_ovf = 1'b0;
    repeat (10) @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (8) @(negedge clk);
    rd(0, 'h6C, "R11 request ignored during reset");

    rd(2, 0, "R12 unused address 2");
    rd(3, 0, "R12 unused address 3");
    rd(1, 3'b010, "R12 strap address");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule